// File: doc/BRIEF.md
# Multi-mode gated measurement counter

This block times events for capacitive-sense style measurements. A single 16-bit counter advances on one of two tick-enable inputs. A mode field in a small control register decides when counting starts and stops. The counter can run freely, or it can run from enable until an event input asserts. It can also time one high pulse of a measured input, or one full period of that input measured between consecutive rising edges. When a gated measurement ends, the count freezes, a one-cycle done pulse fires and a sticky done flag rises. The count is kept until software clears the enable bit and sets it again.

The measured and event inputs first pass through a two-flop synchronizer. A 2-bit select routes one internal signal to a single observation output for debug. The configuration fields are locked while the block runs. A write that tries to change them in that state is dropped and leaves a sticky error bit.

Top module: `gated_meas_counter`

## Requirements
- R1: After reset, the count is zero, the done pulse and done flag are low, the read data is 0x00 and the observation output is low.
- R2: The control byte holds enable in bit 0, the mode in bits [2:1], the tick select in bit 3 and the observation select in bits [5:4]. Read data returns those six bits, with bit 7 showing the write-error flag and bit 6 reading 0. While enable is clear, a write loads all six bits.
- R3: While enable is set, a write updates only bit 0. If its bits [5:1] differ from the stored ones, the write-error flag is set. Writing 1 to bit 7 while enable is clear clears that flag.
- R4: Mode 0 counts from the cycle after enable and stops when the synchronized event input is high.
- R5: Mode 1 ignores a measured input that is already high at enable. It starts after the next synchronized rising edge, counts while the input is high and stops on its falling edge.
- R6: Mode 2 starts after a synchronized rising edge of the measured input and stops on the next rising edge.
- R7: Mode 3 counts from the cycle after enable until enable is cleared, and never signals done.
- R8: While enable is clear, the count, the done flag and all measurement state return to zero one clock later.
- R9: The count rises by at most one per clock and holds at 0xFFFF instead of wrapping.
- R10: Tick select 0 advances the count on tick_a, and tick select 1 advances it on tick_b. The stop cycle itself adds no tick.
- R11: Ending a gated measurement raises done_pulse for exactly one cycle and sets done_flag. The count then holds until enable is cleared.
- R12: Observation select 0 gives the synchronized measured input, 1 the done flag, 2 a one-cycle pulse on a carry out of count bit 7, and 3 the saturated (all ones) indication.
- R13: The measured and event inputs reach the gating logic two clock edges after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register and error flag read data |
| meas_in | input | 1 | Measured input (asynchronous) |
| event_in | input | 1 | Stop event input (asynchronous) |
| tick_a | input | 1 | Tick enable source 0 |
| tick_b | input | 1 | Tick enable source 1 |
| count | output | 16 | Measurement count |
| done_pulse | output | 1 | One-cycle end-of-measurement pulse |
| done_flag | output | 1 | Sticky end-of-measurement flag |
| obs_out | output | 1 | Selected observation signal |

## Verification
A behavioural model in the bench is compared with the block on every clock.

The event mode is driven with a gappy tick pattern and a late event. This shows whether the stop cycle is counted and whether later events are ignored. The pulse-width mode starts with the input already high, which separates waiting for a fresh rising edge from accepting a level. The period mode gets repeated pulses, so a stop on the wrong edge, or a restart after done, shows up as a different count. A long free run with a constant tick reaches saturation and crosses many low-byte carries. A stretch of random writes, ticks and input edges then probes the lock, the error flag and re-arming.

// File: rtl/meas_pkg.sv
package meas_pkg;

  typedef enum logic [1:0] {
    MODE_EVENT  = 2'b00,
    MODE_PULSE  = 2'b01,
    MODE_PERIOD = 2'b10,
    MODE_FREE   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    OBS_MEAS  = 2'b00,
    OBS_DONE  = 2'b01,
    OBS_LOCRY = 2'b10,
    OBS_FULL  = 2'b11
  } obs_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_RUN  = 2'b10,
    ST_DONE = 2'b11
  } gate_state_e;

  // bit order of this struct is the control byte layout [5:0]
  typedef struct packed {
    obs_sel_e  obs_sel;
    logic      tick_sel;
    cnt_mode_e mode;
    logic      en;
  } cfg_t;

  // stop condition of a running measurement
  function automatic logic stop_hit(cnt_mode_e m, logic ev, logic rise, logic fall);
    case (m)
      MODE_EVENT:  return ev;
      MODE_PULSE:  return fall;
      MODE_PERIOD: return rise;
      default:     return 1'b0;
    endcase
  endfunction

  // state entered on the first enabled cycle
  function automatic gate_state_e first_state(cnt_mode_e m);
    return (m == MODE_EVENT || m == MODE_FREE) ? ST_RUN : ST_ARM;
  endfunction

endpackage

// File: rtl/meas_sync.sv
module meas_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign lvl = stg[STAGES-1];

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stg[0]) |-> ##(STAGES-1) lvl); // R13
endmodule

// File: rtl/meas_ctrl_reg.sv
module meas_ctrl_reg
  import meas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output cfg_t       cfg,
  output logic       wr_err,
  output logic       lock_viol,
  output logic [7:0] rdata
);
  logic [5:0] cfg_bits;
  assign cfg_bits  = cfg;
  assign lock_viol = we && cfg.en && (wdata[5:1] != cfg_bits[5:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      wr_err <= 1'b0;
    end else begin
      if (we) begin
        if (cfg.en) cfg.en <= wdata[0];
        else        cfg    <= cfg_t'(wdata[5:0]);
      end
      if (lock_viol)                   wr_err <= 1'b1;
      else if (we && !cfg.en && wdata[7]) wr_err <= 1'b0;
    end
  end

  assign rdata = {wr_err, 1'b0, cfg_bits};

  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cfg.en) |=> (cfg_bits[5:1] == $past(cfg_bits[5:1]))); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_viol |=> wr_err); // R3
endmodule

// File: rtl/meas_gate_fsm.sv
module meas_gate_fsm
  import meas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  cnt_mode_e   mode,
  input  logic        meas_lvl,
  input  logic        ev_lvl,
  input  logic        tick,
  output logic        inc,
  output logic        done_pulse,
  output logic        done_flag,
  output gate_state_e state
);
  logic        meas_prev;
  logic        meas_rise, meas_fall, stop;
  gate_state_e state_nxt;

  assign meas_rise = meas_lvl & ~meas_prev;
  assign meas_fall = ~meas_lvl & meas_prev;
  assign stop      = stop_hit(mode, ev_lvl, meas_rise, meas_fall);
  assign inc       = (state == ST_RUN) && !stop && tick;

  always_comb begin
    state_nxt = state;
    if (!en) state_nxt = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: state_nxt = first_state(mode);
        ST_ARM:  if (meas_rise) state_nxt = ST_RUN;
        ST_RUN:  if (stop) state_nxt = ST_DONE;
        default: state_nxt = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      meas_prev  <= 1'b0;
      done_pulse <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      state      <= state_nxt;
      meas_prev  <= meas_lvl;
      done_pulse <= en && (state == ST_RUN) && stop;
      if (!en)                             done_flag <= 1'b0;
      else if ((state == ST_RUN) && stop)  done_flag <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R11
  AST_FREE_NEVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_FREE) |-> !done_pulse); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE && !done_flag)); // R8
endmodule

// File: rtl/meas_sat_counter.sv
module meas_sat_counter #(
  parameter int W      = 16,
  parameter int LO_BIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         lo_carry,
  output logic         full
);
  localparam logic [W-1:0] MAX = '1;

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic step);
    return (step && c != MAX) ? c + 1'b1 : c;
  endfunction

  function automatic logic carry_out(logic [W-1:0] c, logic step);
    return step && (c != MAX) && (&c[LO_BIT-1:0]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      lo_carry <= 1'b0;
    end else if (clr) begin
      count    <= '0;
      lo_carry <= 1'b0;
    end else begin
      count    <= next_count(count, inc);
      lo_carry <= carry_out(count, inc);
    end
  end

  assign full = (count == MAX);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R8
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1)); // R9
endmodule

// File: rtl/gated_meas_counter.sv
module gated_meas_counter
  import meas_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LO_BIT      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             meas_in,
  input  logic             event_in,
  input  logic             tick_a,
  input  logic             tick_b,
  output logic [CNT_W-1:0] count,
  output logic             done_pulse,
  output logic             done_flag,
  output logic             obs_out
);
  cfg_t        cfg;
  logic        wr_err, lock_viol;
  logic        meas_lvl, ev_lvl, tick, inc, lo_carry, full;
  gate_state_e state;

  meas_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .cfg(cfg), .wr_err(wr_err), .lock_viol(lock_viol), .rdata(reg_rdata)
  );

  meas_sync #(.STAGES(SYNC_STAGES)) u_sync_meas (
    .clk(clk), .rst_n(rst_n), .din(meas_in), .lvl(meas_lvl)
  );

  meas_sync #(.STAGES(SYNC_STAGES)) u_sync_ev (
    .clk(clk), .rst_n(rst_n), .din(event_in), .lvl(ev_lvl)
  );

  assign tick = cfg.tick_sel ? tick_b : tick_a;

  meas_gate_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .mode(cfg.mode),
    .meas_lvl(meas_lvl), .ev_lvl(ev_lvl), .tick(tick), .inc(inc),
    .done_pulse(done_pulse), .done_flag(done_flag), .state(state)
  );

  meas_sat_counter #(.W(CNT_W), .LO_BIT(LO_BIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!cfg.en), .inc(inc),
    .count(count), .lo_carry(lo_carry), .full(full)
  );

  always_comb begin
    case (cfg.obs_sel)
      OBS_MEAS:  obs_out = meas_lvl;
      OBS_DONE:  obs_out = done_flag;
      OBS_LOCRY: obs_out = lo_carry;
      default:   obs_out = full;
    endcase
  end

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && cfg.en) |=> $stable(count)); // R11
  AST_ARM_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM) |=> $stable(count)); // R5
  AST_ERR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_viol |=> reg_rdata[7]); // R3
endmodule

// File: tb/gated_meas_counter_tb_top.sv
module gated_meas_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       meas_in = 1'b0, event_in = 1'b0, tick_a = 1'b0, tick_b = 1'b0;
  logic [15:0] count;
  logic       done_pulse, done_flag, obs_out;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_meas_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .meas_in(meas_in), .event_in(event_in),
    .tick_a(tick_a), .tick_b(tick_b), .count(count),
    .done_pulse(done_pulse), .done_flag(done_flag), .obs_out(obs_out)
  );

  // reference model: state names are plain integers (0 off, 1 armed, 2 running, 3 finished)
  int m_en, m_mode, m_tsel, m_osel, m_err;
  int m_ms[$], m_es[$];
  int m_prev, m_st, m_cnt, m_pulse, m_flag, m_lo;

  task automatic model_reset();
    m_en = 0; m_mode = 0; m_tsel = 0; m_osel = 0; m_err = 0;
    m_ms = '{0, 0}; m_es = '{0, 0};
    m_prev = 0; m_st = 0; m_cnt = 0; m_pulse = 0; m_flag = 0; m_lo = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int ml, el, rise, fall, tk, stp, cur;
      ml = m_ms[1]; el = m_es[1];
      rise = ml && !m_prev; fall = !ml && m_prev;
      tk = m_tsel ? tick_b : tick_a;
      m_pulse = 0; m_lo = 0;
      if (!m_en) begin
        m_st = 0; m_cnt = 0; m_flag = 0;
      end else begin
        case (m_st)
          0: m_st = (m_mode == 0 || m_mode == 3) ? 2 : 1;
          1: if (rise) m_st = 2;
          2: begin
            stp = (m_mode == 0) ? el : (m_mode == 1) ? fall : (m_mode == 2) ? rise : 0;
            if (stp) begin
              m_st = 3; m_pulse = 1; m_flag = 1;
            end else if (tk && m_cnt < 65535) begin
              m_lo = ((m_cnt % 256) == 255);
              m_cnt++;
            end
          end
          default: ;
        endcase
      end
      m_prev = ml;
      void'(m_ms.pop_back()); m_ms.push_front(int'(meas_in));
      void'(m_es.pop_back()); m_es.push_front(int'(event_in));
      if (reg_we) begin
        cur = (m_osel << 4) | (m_tsel << 3) | (m_mode << 1);
        if (m_en) begin
          if ((reg_wdata & 8'h3E) != cur) m_err = 1;
          m_en = reg_wdata[0];
        end else begin
          if (reg_wdata[7]) m_err = 0;
          m_en = reg_wdata[0]; m_mode = reg_wdata[2:1];
          m_tsel = reg_wdata[3]; m_osel = reg_wdata[5:4];
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    int eo, rd;
    cyc++;
    rd = (m_err << 7) | (m_osel << 4) | (m_tsel << 3) | (m_mode << 1) | m_en;
    case (m_osel)
      0: eo = m_ms[1];
      1: eo = m_flag;
      2: eo = m_lo;
      default: eo = (m_cnt == 65535);
    endcase
    chk("count", int'(count), m_cnt);
    chk("done_pulse", int'(done_pulse), m_pulse);
    chk("done_flag", int'(done_flag), m_flag);
    chk("obs_out", int'(obs_out), eo);
    chk("reg_rdata", int'(reg_rdata), rd);
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R1";
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset rdata", int'(reg_rdata), 0);

    cur_req = "R2";
    wr(8'h3A);
    chk("R2 readback", int'(reg_rdata), 8'h3A);
    wr(8'h10); // mode 0, tick_a, observe done

    cur_req = "R4";
    wr(8'h11);
    for (int i = 0; i < 24; i++) begin tick_a = (i % 3 != 1); @(negedge clk); end
    event_in = 1'b1; tick_a = 1'b1; idle(6);
    event_in = 1'b0; idle(4);
    event_in = 1'b1; idle(3); event_in = 1'b0;
    cur_req = "R11";
    chk("R11 done flag", int'(done_flag), 1);
    idle(5);

    cur_req = "R8";
    wr(8'h10); idle(2);
    chk("R8 cleared count", int'(count), 0);
    chk("R8 cleared flag", int'(done_flag), 0);

    cur_req = "R5";
    wr(8'h02); meas_in = 1'b1; idle(4);
    wr(8'h03); idle(6);
    meas_in = 1'b0; idle(4);
    meas_in = 1'b1; idle(10);
    meas_in = 1'b0; idle(5);
    meas_in = 1'b1; idle(7); meas_in = 1'b0; idle(4);
    wr(8'h02); idle(2);

    cur_req = "R6";
    wr(8'h25);
    for (int p = 0; p < 4; p++) begin
      meas_in = 1'b1; idle(3); meas_in = 1'b0; idle(5 + p);
    end
    wr(8'h24); idle(2);

    cur_req = "R10";
    wr(8'h0E); wr(8'h0F);
    for (int i = 0; i < 40; i++) begin
      tick_a = 1'b1; tick_b = (i % 2 == 0); @(negedge clk);
    end

    cur_req = "R3";
    wr(8'h01);
    chk("R3 err set", int'(reg_rdata[7]), 1);
    chk("R3 mode kept", int'(reg_rdata[5:0]), 8'h0F);
    wr(8'h0E); idle(2);
    wr(8'h86);
    chk("R3 err cleared", int'(reg_rdata[7]), 0);

    cur_req = "R12";
    wr(8'h27); tick_b = 1'b0;
    for (int i = 0; i < 700; i++) begin tick_a = (i % 5 != 0); @(negedge clk); end
    wr(8'h26); wr(8'h06); meas_in = 1'b1; idle(6); meas_in = 1'b0; idle(4);

    cur_req = "R9";
    wr(8'h37); tick_a = 1'b1;
    idle(65545);
    chk("R9 saturated", int'(count), 16'hFFFF);
    chk("R9 full observed", int'(obs_out), 1);
    cur_req = "R7";
    chk("R7 no done", int'(done_flag), 0);
    wr(8'h36); idle(2);

    cur_req = "R13";
    for (int i = 0; i < 4000; i++) begin
      meas_in  = ($urandom % 4) == 0 ? ~meas_in : meas_in;
      event_in = ($urandom % 50) == 0;
      tick_a   = $urandom % 2;
      tick_b   = $urandom % 2;
      if (i % 150 == 149) begin
        reg_we = 1'b1; reg_wdata = 8'($urandom);
      end else reg_we = 1'b0;
      @(negedge clk);
    end
    reg_we = 1'b0;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule